// File: doc/BRIEF.md
# Phase-Accumulator Pulse-Width Modulator

This block produces a pulse-width modulated output whose period is set by a phase accumulator instead of a period counter. On every enabled clock a programmable increment is added to a wrap-around counter of `INT_W + FRAC_W` bits. The increment has an 8-bit integer part in its upper bits and a fractional part of `FRAC_W` bits below it. Each carry out of that addition ends one output period. The output frequency is therefore `f_clk * increment / 2^(INT_W+FRAC_W)`.

The duty cycle comes from an 8-bit threshold that is compared with the counter's top byte. A threshold near 255 gives a nearly-always-low output, and a small threshold gives a nearly-always-high output. A zero increment or a zero threshold holds the output low.

Software-side logic writes a new increment/threshold pair with a one-cycle update strobe. The pair waits in a staging register and moves into the active settings only at the next counter wrap, so a period is never cut short. This has a consequence the block keeps on purpose. A zero active increment never wraps the counter, so an update written in that state stays pending until the block is disabled. Disabling clears the counter and drives the output low, and the staged pair is then loaded directly.

Top module: `pwm_acc_gen`

## Requirements
- R1: After reset the counter, the staging and active settings and the pending flag are all zero, and `pwm_o` is low.
- R2: On every clock with `en` high, the counter becomes (counter + active increment) modulo 2^(INT_W+FRAC_W). A carry out of that sum marks a wrap, which ends one period.
- R3: While `en` is high and both active settings are nonzero, `pwm_o` is high exactly when the counter's top INT_W bits, read as an unsigned number, are greater than or equal to the active threshold.
- R4: While the active increment is zero, `pwm_o` is low.
- R5: While the active threshold is zero, `pwm_o` is low.
- R6: A clock with `upd_stb` high copies `base_in` (integer part in bits [ACC_W-1:FRAC_W], fraction below) and `duty_in` into staging and arms the pending flag. The active settings do not change on that clock.
- R7: On a wrap with the pending flag set, both staged values become active together and the flag clears. Without a wrap, an enabled block keeps its active settings.
- R8: With a zero active increment and `en` high, the counter holds its value, and a pending update stays pending for as long as `en` stays high.
- R9: With `en` low, `pwm_o` is low and the counter is zero after the next clock. On every such clock the staged values are copied into the active settings and the pending flag clears, unless a strobe arrives on that clock.
- R10: A strobe on the same clock as a wrap moves the previously staged pair into the active settings, stores the new pair and leaves the pending flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; low clears the counter and forces the output low |
| upd_stb | input | 1 | One-cycle strobe that stages `base_in`/`duty_in` |
| base_in | input | INT_W+FRAC_W | Increment: integer part high, fraction low |
| duty_in | input | INT_W | On-time threshold |
| pwm_o | output | 1 | Modulated output |

## Verification
The assertions check on every cycle that the output stays low with a zero increment or a zero threshold. They also check that the active settings move only on a wrap or while disabled, that a strobe always arms the pending flag, that a zero increment freezes the counter, and that disabling clears the counter. Only the bench's scenarios can show the period and the high time that come from a given increment and threshold. The same holds for the wait of a staged pair until the end of a period, the strobe that lands on the exact wrap cycle, and the lock-up that a zero increment causes and that only disabling releases.

// File: rtl/pwm_acc_pkg.sv
package pwm_acc_pkg;

  // Width of the threshold and of the integer part of the increment
  localparam int DUTY_W = 8;

  // Reason the output takes its current level
  typedef enum logic [1:0] {
    SRC_IDLE      = 2'd0,
    SRC_ZERO_BASE = 2'd1,
    SRC_ZERO_DUTY = 2'd2,
    SRC_COMPARE   = 2'd3
  } pwm_src_e;

  // Level for a running, nonzero configuration
  function automatic logic level_from(input logic [DUTY_W-1:0] top_byte,
                                      input logic [DUTY_W-1:0] thresh);
    return (top_byte >= thresh);
  endfunction

  // Classify why the output is (or may be) driven
  function automatic pwm_src_e classify(input logic run,
                                       input logic base_nz,
                                       input logic duty_nz);
    if (!run)          return SRC_IDLE;
    else if (!base_nz) return SRC_ZERO_BASE;
    else if (!duty_nz) return SRC_ZERO_DUTY;
    else               return SRC_COMPARE;
  endfunction

endpackage

// File: rtl/pwm_acc_stage.sv
module pwm_acc_stage #(
  parameter int ACC_W  = 16,
  parameter int DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              upd_stb,
  input  logic [ACC_W-1:0]  base_in,
  input  logic [DUTY_W-1:0] duty_in,
  input  logic              wrap,
  output logic [ACC_W-1:0]  act_base,
  output logic [DUTY_W-1:0] act_duty,
  output logic              pend_o
);

  logic [ACC_W-1:0]  stg_base;
  logic [DUTY_W-1:0] stg_duty;
  logic              pend;
  logic              load_now;

  // Active settings follow staging while idle, or on a wrap with an armed update
  assign load_now = !en || (wrap && pend);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_base <= '0;
      stg_duty <= '0;
      act_base <= '0;
      act_duty <= '0;
      pend     <= 1'b0;
    end else begin
      if (load_now) begin
        act_base <= stg_base;
        act_duty <= stg_duty;
      end
      if (upd_stb) begin
        stg_base <= base_in;
        stg_duty <= duty_in;
        pend     <= 1'b1;
      end else if (load_now) begin
        pend     <= 1'b0;
      end
    end
  end

  assign pend_o = pend;

  // R7
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wrap) |=> ($stable(act_base) && $stable(act_duty)));

  // R6
  strobe_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |=> pend_o);

endmodule

// File: rtl/pwm_acc_phase.sv
module pwm_acc_phase #(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [ACC_W-1:0] inc,
  output logic [ACC_W-1:0] acc,
  output logic             wrap
);

  logic [ACC_W:0] sum_ext;

  // Sum with the carry in the top bit
  function automatic logic [ACC_W:0] add_carry(input logic [ACC_W-1:0] a,
                                               input logic [ACC_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  assign sum_ext = add_carry(acc, inc);
  assign wrap    = en && sum_ext[ACC_W];

  always_ff @(posedge clk) begin
    if (!rst_n)   acc <= '0;
    else if (!en) acc <= '0;
    else          acc <= sum_ext[ACC_W-1:0];
  end

  // R9
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (acc == '0));

  // R8
  zero_inc_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && inc == '0) |=> $stable(acc));

endmodule

// File: rtl/pwm_acc_cmp.sv
module pwm_acc_cmp
  import pwm_acc_pkg::*;
#(
  parameter int ACC_W = 16
) (
  input  logic              en,
  input  logic [ACC_W-1:0]  act_base,
  input  logic [DUTY_W-1:0] act_duty,
  input  logic [ACC_W-1:0]  acc,
  output pwm_src_e          src,
  output logic              pwm
);

  logic [DUTY_W-1:0] top_byte;

  assign top_byte = acc[ACC_W-1 -: DUTY_W];
  assign src      = classify(en, act_base != '0, act_duty != '0);
  assign pwm      = (src == SRC_COMPARE) && level_from(top_byte, act_duty);

endmodule

// File: rtl/pwm_acc_gen.sv
module pwm_acc_gen
  import pwm_acc_pkg::*;
#(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    upd_stb,
  input  logic [INT_W+FRAC_W-1:0] base_in,
  input  logic [INT_W-1:0]        duty_in,
  output logic                    pwm_o
);

  localparam int ACC_W = INT_W + FRAC_W;

  logic [ACC_W-1:0]  act_base;
  logic [DUTY_W-1:0] act_duty;
  logic [ACC_W-1:0]  acc;
  logic              wrap_evt;
  logic              pend;
  pwm_src_e          out_src;

  pwm_acc_stage #(.ACC_W(ACC_W), .DUTY_W(DUTY_W)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .upd_stb  (upd_stb),
    .base_in  (base_in),
    .duty_in  (duty_in),
    .wrap     (wrap_evt),
    .act_base (act_base),
    .act_duty (act_duty),
    .pend_o   (pend)
  );

  pwm_acc_phase #(.ACC_W(ACC_W)) u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .inc   (act_base),
    .acc   (acc),
    .wrap  (wrap_evt)
  );

  pwm_acc_cmp #(.ACC_W(ACC_W)) u_cmp (
    .en       (en),
    .act_base (act_base),
    .act_duty (act_duty),
    .acc      (acc),
    .src      (out_src),
    .pwm      (pwm_o)
  );

  // R4
  zero_base_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_base == '0) |-> !pwm_o);

  // R5
  zero_duty_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_duty == '0) |-> !pwm_o);

  // R8
  locked_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && act_base == '0 && pend && !upd_stb) |=> (pend && act_base == '0));

endmodule

// File: tb/pwm_acc_gen_test.sv
module pwm_acc_gen_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        en;
  logic        upd_stb;
  logic [15:0] base_in;
  logic [7:0]  duty_in;
  logic        pwm_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference state, built from the requirements
  int m_acc, m_ab, m_ad, m_sb, m_sd;
  bit m_p;

  always #4 clk = ~clk;  // 125 MHz

  pwm_acc_gen uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .upd_stb (upd_stb),
    .base_in (base_in),
    .duty_in (duty_in),
    .pwm_o   (pwm_o)
  );

  // {increment, threshold, cycles}
  localparam logic [39:0] VEC [8] = '{
    {16'h0100, 8'h80, 16'd600},
    {16'h0340, 8'h40, 16'd400},
    {16'h1000, 8'hC0, 16'd200},
    {16'hFFFF, 8'h01, 16'd100},
    {16'h0080, 8'hFF, 16'd1200},
    {16'h2A55, 8'h10, 16'd200},
    {16'h0100, 8'h00, 16'd400},
    {16'h0180, 8'h20, 16'd500}
  };

  task automatic check(input bit act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: pwm_o=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock: drive, advance the model at the edge, compare shortly after
  task automatic step(input bit e, input bit s, input int b, input int d,
                      input string tag);
    int  sum;
    bit  exp;
    en = e; upd_stb = s; base_in = b[15:0]; duty_in = d[7:0];
    @(posedge clk);
    if (!e) begin
      m_acc = 0; m_ab = m_sb; m_ad = m_sd; m_p = 0;
    end else begin
      sum = m_acc + m_ab;
      m_acc = sum % 65536;
      if (sum >= 65536 && m_p) begin
        m_ab = m_sb; m_ad = m_sd; m_p = 0;
      end
    end
    if (s) begin m_sb = b; m_sd = d; m_p = 1; end
    #2;
    exp = e && (m_ab != 0) && (m_ad != 0) && ((m_acc / 256) >= m_ad);
    check(pwm_o, exp, tag);
  endtask

  function automatic string run_tag(input bit e);
    if (!e)           return "R9";
    else if (m_ab==0) return "R4";
    else if (m_ad==0) return "R5";
    else              return "R2 R3 R6 R7";
  endfunction

  initial begin
    int highs;
    rst_n = 1'b0; en = 1'b0; upd_stb = 1'b0; base_in = '0; duty_in = '0;
    m_acc = 0; m_ab = 0; m_ad = 0; m_sb = 0; m_sd = 0; m_p = 0;
    repeat (3) @(posedge clk);
    #2;
    check(pwm_o, 1'b0, "R1 reset");
    rst_n = 1'b1;
    // R1 / R4: enabled straight after reset, all settings zero
    for (int i = 0; i < 5; i++) step(1, 0, 0, 0, "R1 R4");

    // Load first vector while disabled
    step(0, 1, VEC[0][39:24], VEC[0][23:16], "R9");
    step(0, 0, 0, 0, "R9");
    for (int v = 0; v < 8; v++) begin
      if (v > 0) step(1, 1, VEC[v][39:24], VEC[v][23:16], "R6");
      for (int c = 0; c < int'(VEC[v][15:0]); c++) step(1, 0, 0, 0, run_tag(1));
    end

    // R10: strobe exactly on a wrap cycle with an earlier pair pending
    step(1, 1, 16'h0800, 8'h40, "R6");
    while (m_acc + m_ab < 65536) step(1, 0, 0, 0, run_tag(1));
    step(1, 1, 16'h0400, 8'hE0, "R10");
    checks++;
    if (!(m_p == 1 && m_ab == 16'h0800)) begin
      fails++;
      $display("FAIL R10: model pend=%0d base=%0h expected 1/800", m_p, m_ab);
    end
    for (int c = 0; c < 400; c++) step(1, 0, 0, 0, "R10");

    // R8: zero increment locks out a later update while enabled
    step(0, 1, 0, 8'h80, "R9");
    step(0, 0, 0, 0, "R9");
    step(1, 1, 16'h0400, 8'h80, "R8");
    highs = 0;
    for (int c = 0; c < 600; c++) begin
      step(1, 0, 0, 0, "R8");
      if (pwm_o) highs++;
    end
    checks++;
    if (highs != 0) begin
      fails++;
      $display("FAIL R8: high cycles=%0d expected 0", highs);
    end
    // R9: disabling releases it
    step(0, 0, 0, 0, "R9");
    highs = 0;
    for (int c = 0; c < 300; c++) begin
      step(1, 0, 0, 0, run_tag(1));
      if (pwm_o) highs++;
    end
    checks++;
    if (highs == 0) begin
      fails++;
      $display("FAIL R9: high cycles=%0d expected >0", highs);
    end
    for (int c = 0; c < 20; c++) step(0, 0, 0, 0, "R9");

    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: run incomplete, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule